// File: doc/BRIEF.md
# Two-Phase 4x4 Matrix Transpose Sequencer

This block turns a 4x4 matrix of fixed-width elements into its transpose. The matrix arrives as four row vectors of four lanes each. The block never routes an element straight from any input position to any output position. Each step is a shuffle that draws from two 4-lane source rows and picks, for every output lane, one of the two sources and a lane inside it. A single shared shuffle unit runs eight such steps, one per clock.

In the first phase the four 2x2 corner sub-blocks are transposed into an intermediate bank. In the second phase the off-diagonal 2x2 blocks are exchanged, and the result goes into the output bank one row per cycle. A one-cycle start pulse captures the input rows. A one-cycle done pulse marks that the result is complete, and the output rows then stay where they are until the next accepted start.

Top module: `mat_xpose_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and every bit of `out_rows` is 0.
- R2: A `start` sampled high on a clock edge while `busy` is 0 is accepted, and `busy` reads 1 in the cycle after that edge.
- R3: `done` is high for exactly one cycle, in the cycle after the eighth clock edge that follows the accepting edge. `busy` drops to 0 in that same cycle.
- R4: When `done` is high, element (row r, lane l) of `out_rows` equals element (row l, lane r) of the captured input. Element (row r, lane l) sits at bits [(4*r+l)*ELEM_W +: ELEM_W] of both `in_rows` and `out_rows`.
- R5: A `start` that arrives while `busy` is 1 is ignored. The done time and the result both belong to the start that was accepted first.
- R6: While `busy` is 0, `out_rows` does not change. This holds whatever values `in_rows` takes in that time.
- R7: `in_rows` is captured only on the accepting edge. Changes to it while `busy` is 1 have no effect on the result.
- R8: Output row k (k = 0..3) is written on edge 5+k after the accepting edge. Rows with a larger index keep their previous contents until their own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transpose; honoured only while idle |
| in_rows | input | 16*ELEM_W | Four input rows of four lanes, row-major |
| busy | output | 1 | High while the eight shuffle steps run |
| done | output | 1 | One-cycle pulse when the output is complete |
| out_rows | output | 16*ELEM_W | Transposed matrix, row-major, held when idle |

## Verification
`busy` is due one cycle after the accepting edge. Output row k is due five plus k cycles after it, and `done` together with the full transposed matrix is due eight cycles after it. The bench drives `start` on a falling edge and counts falling edges from the accepting rising edge, so each sample falls in the middle of the cycle a result is due. At that sample it compares the ports with values it works out by index swapping. It checks `busy` and `done` in every one of the eight cycles, checks the partial output after the fifth cycle, and then spends idle cycles confirming that the held result does not move.

// File: rtl/mxs_pkg.sv
// Shared constants, types and step-plan functions for the transpose sequencer.
// Assumes a fixed 4x4 geometry: the two-phase shuffle schedule only holds there.
package mxs_pkg;
    localparam int DIM     = 4;
    localparam int LIDX_W  = 2;
    localparam int STEPS   = 2 * DIM;
    localparam int STEP_W  = 3;
    localparam int PICK_W  = LIDX_W + 1;
    localparam int PLAN_W  = DIM * PICK_W;

    typedef enum logic {PH_CORNER = 1'b0, PH_BLOCK = 1'b1} phase_e;

    typedef struct packed {
        logic              from_b;
        logic [LIDX_W-1:0] lane;
    } lane_pick_t;

    // Per-lane pick plan for one shuffle step of a given phase and slot.
    function automatic logic [PLAN_W-1:0] pick_plan(phase_e ph, logic [1:0] slot);
        logic [PLAN_W-1:0] plan;
        lane_pick_t        p;
        plan = '0;
        for (int l = 0; l < DIM; l++) begin
            logic [1:0] lv;
            lv = 2'(l);
            if (ph == PH_CORNER) begin
                p.from_b = lv[0];
                p.lane   = {lv[1], slot[0]};
            end else begin
                p.from_b = lv[1];
                p.lane   = {slot[1], lv[0]};
            end
            plan[l*PICK_W +: PICK_W] = p;
        end
        return plan;
    endfunction

    // Row index feeding shuffle input A for a step.
    function automatic logic [1:0] src_a_row(phase_e ph, logic [1:0] slot);
        return (ph == PH_CORNER) ? {slot[1], 1'b0} : {1'b0, slot[0]};
    endfunction

    // Row index feeding shuffle input B for a step.
    function automatic logic [1:0] src_b_row(phase_e ph, logic [1:0] slot);
        return (ph == PH_CORNER) ? {slot[1], 1'b1} : {1'b1, slot[0]};
    endfunction
endpackage

// File: rtl/mxs_sequencer.sv
// Step controller: accepts start while idle, then walks eight shuffle steps.
// It reports the phase and the slot of each step, and pulses done with the
// last write. A start that arrives while busy is dropped.
module mxs_sequencer
    import mxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        accept,
    output logic        busy,
    output logic        done,
    output phase_e      phase,
    output logic [1:0]  slot
);
    logic [STEP_W-1:0] step_q;

    assign accept = start && !busy;
    assign phase  = phase_e'(step_q[STEP_W-1]);
    assign slot   = step_q[1:0];

    // Advance the step counter and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            step_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                step_q <= '0;
            end else if (busy) begin
                step_q <= step_q + 1'b1;
                if (step_q == STEP_W'(STEPS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mxs_row_bank.sv
// Bank of DIM row registers. It can load all rows at once or write a single
// row by index. A row holds its value when neither kind of write targets it.
module mxs_row_bank
    import mxs_pkg::*;
#(
    parameter int ROW_W = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [DIM*ROW_W-1:0] load_data,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [ROW_W-1:0]     wr_data,
    output logic [DIM*ROW_W-1:0] rows
);
    for (genvar r = 0; r < DIM; r++) begin : g_row
        // Update one row from a bulk load or an indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[r*ROW_W +: ROW_W] <= '0;
            end else if (load_en) begin
                rows[r*ROW_W +: ROW_W] <= load_data[r*ROW_W +: ROW_W];
            end else if (wr_en && (wr_idx == 2'(r))) begin
                rows[r*ROW_W +: ROW_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/mxs_lane_shuffle.sv
// Combinational two-source lane shuffle. Every output lane takes one lane of
// either source A or source B, as the per-lane pick plan directs.
module mxs_lane_shuffle
    import mxs_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic [DIM*ELEM_W-1:0] src_a,
    input  logic [DIM*ELEM_W-1:0] src_b,
    input  logic [PLAN_W-1:0]     plan,
    output logic [DIM*ELEM_W-1:0] y
);
    for (genvar l = 0; l < DIM; l++) begin : g_lane
        lane_pick_t pick;
        assign pick = plan[l*PICK_W +: PICK_W];
        // Select the source element for this output lane.
        always_comb begin
            if (pick.from_b) y[l*ELEM_W +: ELEM_W] = src_b[pick.lane*ELEM_W +: ELEM_W];
            else             y[l*ELEM_W +: ELEM_W] = src_a[pick.lane*ELEM_W +: ELEM_W];
        end
    end
endmodule

// File: rtl/mat_xpose_seq.sv
// Top level of the 4x4 transpose sequencer. The input bank captures the
// matrix on an accepted start. One shared shuffle unit then fills the
// intermediate bank (corner phase) and the output bank (block phase), one row
// per clock. Assumes row-major packing of elements: row r, lane l at index 4r+l.
module mat_xpose_seq
    import mxs_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [DIM*DIM*ELEM_W-1:0] in_rows,
    output logic                     busy,
    output logic                     done,
    output logic [DIM*DIM*ELEM_W-1:0] out_rows
);
    localparam int ROW_W = DIM * ELEM_W;

    logic                 accept;
    phase_e               phase;
    logic [1:0]           slot;
    logic [DIM*ROW_W-1:0] src_rows;
    logic [DIM*ROW_W-1:0] mid_rows;
    logic [DIM*ROW_W-1:0] bank_sel;
    logic [ROW_W-1:0]     row_a;
    logic [ROW_W-1:0]     row_b;
    logic [ROW_W-1:0]     shuf_row;
    logic [PLAN_W-1:0]    plan;
    logic                 mid_we;
    logic                 out_we;

    mxs_sequencer u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .phase  (phase),
        .slot   (slot)
    );

    mxs_row_bank #(.ROW_W(ROW_W)) u_src_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (accept),
        .load_data (in_rows),
        .wr_en     (1'b0),
        .wr_idx    (2'b00),
        .wr_data   ('0),
        .rows      (src_rows)
    );

    // Pick the bank and rows that feed the shuffle for the current step.
    always_comb begin
        bank_sel = (phase == PH_CORNER) ? src_rows : mid_rows;
        row_a    = bank_sel[src_a_row(phase, slot)*ROW_W +: ROW_W];
        row_b    = bank_sel[src_b_row(phase, slot)*ROW_W +: ROW_W];
        plan     = pick_plan(phase, slot);
        mid_we   = busy && (phase == PH_CORNER);
        out_we   = busy && (phase == PH_BLOCK);
    end

    mxs_lane_shuffle #(.ELEM_W(ELEM_W)) u_shuf (
        .src_a (row_a),
        .src_b (row_b),
        .plan  (plan),
        .y     (shuf_row)
    );

    mxs_row_bank #(.ROW_W(ROW_W)) u_mid_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (1'b0),
        .load_data ('0),
        .wr_en     (mid_we),
        .wr_idx    (slot),
        .wr_data   (shuf_row),
        .rows      (mid_rows)
    );

    mxs_row_bank #(.ROW_W(ROW_W)) u_out_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (1'b0),
        .load_data ('0),
        .wr_en     (out_we),
        .wr_idx    (slot),
        .wr_data   (shuf_row),
        .rows      (out_rows)
    );
endmodule

// File: rtl/mxs_checker.sv
// Property checker for mat_xpose_seq, bound to every instance of it. It keeps
// its own run-length counter and a shadow of the captured matrix, so it can
// check timing and the transposed result without reading design internals.
module mxs_checker
    import mxs_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic                      busy,
    input logic                      done,
    input logic [DIM*DIM*ELEM_W-1:0] in_rows,
    input logic [DIM*DIM*ELEM_W-1:0] out_rows
);
    logic [3:0]                run_cnt;
    logic [DIM*DIM*ELEM_W-1:0] shadow;
    logic [DIM*DIM*ELEM_W-1:0] shadow_t;

    // Count the cycles of a run and keep a copy of the accepted matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            shadow  <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            shadow  <= in_rows;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Transpose the shadow by direct index swap as the reference.
    always_comb begin
        for (int r = 0; r < DIM; r++)
            for (int l = 0; l < DIM; l++)
                shadow_t[(r*DIM+l)*ELEM_W +: ELEM_W] = shadow[(l*DIM+r)*ELEM_W +: ELEM_W];
    end

    assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("R2 busy not raised");

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("R3 done longer than one cycle");

    assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 4'd8)) else $error("R3 done at wrong cycle");

    assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("R3 busy fell without done");

    assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_rows == shadow_t)) else $error("R4 wrong transpose");

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(out_rows)) else $error("R6 output moved while idle");
endmodule

bind mat_xpose_seq mxs_checker #(.ELEM_W(ELEM_W)) u_mxs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .in_rows  (in_rows),
    .out_rows (out_rows)
);

// File: tb/mat_xpose_seq_test.sv
// Self-checking bench for mat_xpose_seq with 32-bit elements. It sweeps a single
// nonzero element over all 16 positions and runs hashed dense matrices and
// corner patterns. It also injects start and new input data while a run is in
// progress, and checks idle-time holding.
module mat_xpose_seq_test;
    localparam int EW = 32;
    localparam int MW = 16 * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] in_rows = '0;
    logic          busy;
    logic          done;
    logic [MW-1:0] out_rows;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    mat_xpose_seq #(.ELEM_W(EW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_rows  (in_rows),
        .busy     (busy),
        .done     (done),
        .out_rows (out_rows)
    );

    function automatic logic [MW-1:0] xpose(logic [MW-1:0] m);
        logic [MW-1:0] t;
        for (int r = 0; r < 4; r++)
            for (int l = 0; l < 4; l++)
                t[(r*4+l)*EW +: EW] = m[(l*4+r)*EW +: EW];
        return t;
    endfunction

    function automatic logic [MW-1:0] hashed(int seed);
        logic [MW-1:0] m;
        for (int p = 0; p < 16; p++)
            m[p*EW +: EW] = (32'(seed) * 32'h0100_0193) ^ (32'(p + 1) * 32'h9E37_79B9);
        return m;
    endfunction

    task automatic chk(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full transpose run; poke = inject a second start mid-run (R5).
    task automatic run(input logic [MW-1:0] m, input bit poke);
        logic [MW-1:0] prev;
        logic [MW-1:0] exp;
        prev = out_rows;
        exp  = xpose(m);
        in_rows = m;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        in_rows = ~m;                                   // R7: disturb inputs while busy
        chk("R2 busy after accept", MW'(busy), MW'(1));
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            start = poke && (k == 3);
            if (poke && k == 3) in_rows = hashed(999);
            chk("R3 done timing", MW'(done), MW'(k == 8));
            chk("R3 busy timing", MW'(busy), MW'(k < 8));
            if (k == 5) begin
                chk("R8 row0 written", MW'(out_rows[127:0]), MW'(exp[127:0]));
                chk("R8 rows1-3 held", MW'(out_rows[MW-1:128]), MW'(prev[MW-1:128]));
            end
        end
        start = 1'b0;
        if (poke) chk("R5 result from first start", out_rows, exp);
        else      chk("R4 transpose R7 captured", out_rows, exp);
        // R6: idle cycles with wandering inputs; output must hold.
        for (int k = 0; k < 3; k++) begin
            in_rows = hashed(k + 500);
            @(negedge clk);
            chk("R6 output held", out_rows, exp);
            chk("R6 idle done low", MW'({busy, done}), MW'(0));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy/done", MW'({busy, done}), MW'(0));
        chk("R1 reset out_rows", out_rows, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", MW'({busy, done}), MW'(0));
        for (int p = 0; p < 16; p++) begin
            logic [MW-1:0] m;
            m = '0;
            m[p*EW +: EW] = 32'hA500_0000 | 32'(p + 1);
            run(m, 1'b0);
        end
        for (int s = 1; s <= 8; s++) run(hashed(s), 1'b0);
        run({MW{1'b1}}, 1'b0);
        run(hashed(40), 1'b1);
        run(hashed(41), 1'b1);
        run('0, 1'b0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule